// File: doc/BRIEF.md
# Dual-Output PWM Timer Channel

This block is one timer channel built around a single 16-bit up-counter. The counter feeds two PWM outputs. Each output has its own pair of compare registers: one sets the period and the other sets the duty point. Both outputs share one prescaler and one counter-clear source, so they run on a common time base. The clear source is the period register of either output, picked in the control register.

Software drives the channel through a small write/read port. A control register selects the clock divider and the clear source. A run bit starts and stops the count. An I/O control register enables each output pin; a disabled pin floats. Each compare register has a software-visible buffer. While the counter runs, a new compare value waits in that buffer until the next period boundary, so a period never mixes old and new settings.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset the counter, every register and the run bit are 0, both `pwm_oe` bits are 0, and both `pwm_o` bits are 0.
- R2: While the run bit (address 1, bit 0) is 1, the counter advances by one on each prescaled tick. While the run bit is 0 the counter holds its value and the prescaler restarts from zero. A write that clears the run bit still lets the tick of that same edge take place.
- R3: The prescaler select (address 0, bits 1:0) takes values 0..3. It produces one tick every 1, 4, 16 or 64 clocks, and the first tick comes that many clocks after the run bit is set.
- R4: The clear-source bit (address 0, bit 2) chooses the period register that clears the counter: 0 picks compare A (address 4), 1 picks compare C (address 6). On a tick where the counter equals that period value, the counter goes to 0, so it steps through 0..P.
- R5: With normal polarity, output 0 is high while the counter is below compare B (address 5), and output 1 is high while the counter is below compare D (address 7). Each is low from its duty match to the end of the period.
- R6: A duty value of 0 gives a constant low level. A nonzero duty value greater than or equal to its output's period value (A for output 0, C for output 1) gives a constant high level.
- R7: An output whose enable bit at address 2 is 0 (bit 0 for output 0, bit 1 for output 1) has `pwm_oe` low, `pwm_o` low and its pad at high impedance.
- R8: A write to the control register at address 0 while the run bit is 1 is ignored. Reading address 0 still returns the old value. The same write while stopped is stored.
- R9: Compare registers read back the last value written. While stopped, a write takes effect at once. While running, the written value takes effect only at the next counter clear.
- R10: Address 3 reads the current counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| pwm_o | output | 2 | PWM level per output, forced low when that output is disabled |
| pwm_oe | output | 2 | Pad drive enable per output |
| pwm_pad | output | 2 | Tristate pad, high impedance when disabled |

## Verification
A write lands on the clock edge that samples it. Register readback and the enable pins change right after that edge. Compare effects appear on the first tick that follows. The run bit written on edge e0 produces no tick on e0. At divide-by-one the first increment happens on edge e0+1. At divide-by-4^s the first increment happens on edge e0+4^s. The PWM levels are combinational from the counter, so they follow it with no extra cycle. The bench moves one edge at a time, drives inputs at the falling edge, and samples just after it. This lets each expected counter value and level be computed from the number of edges since the run write.

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic [1:0]    pwm_o,
  output logic [1:0]    pwm_oe,
  output logic [1:0]    pwm_pad
);
  localparam int PDW = 6;
  localparam int NCMP = 4;

  logic [1:0]               psel;
  logic                     clr_c;
  logic                     run_q;
  logic [1:0]               io_en;
  logic [CW-1:0]            cnt;
  logic [PDW-1:0]           pdiv;
  logic [NCMP-1:0][CW-1:0]  shd;
  logic [NCMP-1:0][CW-1:0]  act;

  wire [PDW-1:0] pmask   = PDW'((32'd1 << (2 * psel)) - 32'd1);
  wire           tick    = run_q && ((pdiv & pmask) == pmask);
  wire [CW-1:0]  per_clr = clr_c ? act[2] : act[0];
  wire           wrap    = tick && (cnt == per_clr);
  wire           cmp_wr  = wr_en && addr[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel  <= '0;
      clr_c <= 1'b0;
      run_q <= 1'b0;
      io_en <= '0;
      cnt   <= '0;
      pdiv  <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          AW'(0): if (!run_q) {clr_c, psel} <= wr_data[2:0];
          AW'(1): run_q <= wr_data[0];
          AW'(2): io_en <= wr_data[1:0];
          default: ;
        endcase
      end
      pdiv <= run_q ? pdiv + PDW'(1) : '0;
      if (tick) cnt <= wrap ? '0 : cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0;
      act <= '0;
    end else begin
      for (int k = 0; k < NCMP; k++) begin
        if (cmp_wr && addr[1:0] == 2'(k)) begin
          shd[k] <= wr_data;
          if (!run_q) act[k] <= wr_data;
        end
        if (run_q && wrap) act[k] <= shd[k];
      end
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rd_data = CW'({clr_c, psel});
      AW'(1):  rd_data = CW'(run_q);
      AW'(2):  rd_data = CW'(io_en);
      AW'(3):  rd_data = cnt;
      default: rd_data = shd[addr[1:0]];
    endcase
  end

  for (genvar i = 0; i < 2; i++) begin : g_out
    wire [CW-1:0] per = act[2*i];
    wire [CW-1:0] dty = act[2*i+1];
    wire          lvl = (dty != '0) && ((dty >= per) || (cnt < dty));
    assign pwm_o[i]   = io_en[i] & lvl;
    assign pwm_oe[i]  = io_en[i];
    assign pwm_pad[i] = io_en[i] ? lvl : 1'bz;

    p_zero_duty_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dty == '0) |-> !pwm_o[i]);
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe[i] |-> !pwm_o[i]);
  end

  p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt));
  p_clear_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  p_ctrl_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ($stable(psel) && $stable(clr_c)));
  p_active_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap) |=> $stable(act));
endmodule

// File: tb/tb_pwm_timer_ch.sv
`timescale 1ns/1ps
module tb_pwm_timer_ch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  pwm_o, pwm_oe, pwm_pad;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  pwm_timer_ch dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
    .pwm_pad(pwm_pad));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = 3'(a); wr_data = 16'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk("R1 pwm_oe after reset", int'(pwm_oe), 0);
    chk("R1 pwm_o after reset", int'(pwm_o), 0);
  endtask

  task automatic t_count_pwm();
    int v, c;
    do_reset();
    wr(4, 9); wr(5, 3); wr(6, 9); wr(7, 7); wr(2, 3);
    wr(1, 1);
    for (int k = 1; k <= 20; k++) begin
      step();
      c = k % 10;
      rd(3, v);
      chk("R2/R4 counter sequence", v, c);
      chk("R5 output0 level", int'(pwm_o[0]), int'(c < 3));
      chk("R5 output1 level", int'(pwm_o[1]), int'(c < 7));
    end
    wr(1, 0);
    rd(3, v);
    chk("R2 tick on stopping edge", v, 1);
    repeat (3) step();
    rd(3, v);
    chk("R2 counter holds when stopped", v, 1);
  endtask

  task automatic t_presc();
    int v, d;
    for (int s = 1; s <= 3; s++) begin
      do_reset();
      d = 1 << (2 * s);
      wr(4, 16'hFFFF);
      wr(0, s);
      wr(1, 1);
      for (int k = 1; k <= 3 * d; k++) begin
        step();
        if (k == d - 1 || k == d || k == 3 * d) begin
          rd(3, v);
          chk($sformatf("R3 divide by %0d after %0d clocks", d, k), v, k / d);
        end
      end
    end
  endtask

  task automatic t_clrsrc();
    int v;
    do_reset();
    wr(4, 2); wr(6, 5); wr(0, 4);
    wr(1, 1);
    for (int k = 1; k <= 14; k++) begin
      step();
      rd(3, v);
      chk("R4 clear from compare C", v, k % 6);
    end
  endtask

  task automatic t_extremes();
    do_reset();
    wr(4, 5); wr(5, 0); wr(6, 5); wr(7, 12); wr(2, 3);
    wr(1, 1);
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R6 duty 0 constant low", int'(pwm_o[0]), 0);
      chk("R6 duty above period constant high", int'(pwm_o[1]), 1);
    end
  endtask

  task automatic t_hiz();
    do_reset();
    wr(4, 5); wr(5, 6); wr(6, 5); wr(7, 6);
    wr(2, 1);
    chk("R7 only output0 enabled", int'(pwm_oe), 1);
    chk("R7 disabled output1 low", int'(pwm_o[1]), 0);
    chk("R7 enabled output0 drives", int'(pwm_o[0]), 1);
    wr(2, 0);
    chk("R7 both disabled", int'(pwm_oe), 0);
    chk("R7 both levels low", int'(pwm_o), 0);
  endtask

  task automatic t_ctrl_lock();
    int v;
    do_reset();
    wr(4, 100);
    wr(1, 1);
    wr(0, 2);
    rd(0, v);
    chk("R8 control write ignored while running", v, 0);
    step();
    rd(3, v);
    chk("R8 divider unchanged, counter at 2", v, 2);
    wr(1, 0);
    wr(0, 2);
    rd(0, v);
    chk("R8 control write stored while stopped", v, 2);
  endtask

  task automatic t_shadow();
    int v, e;
    do_reset();
    wr(4, 9);
    wr(1, 1);
    repeat (3) step();
    wr(4, 4);
    rd(4, v);
    chk("R9 readback of buffered compare", v, 4);
    rd(3, v);
    chk("R10 counter read at 4", v, 4);
    for (int k = 5; k <= 15; k++) begin
      step();
      e = (k <= 9) ? k : (k == 10 ? 0 : (k - 10) % 5);
      rd(3, v);
      chk("R9 new period only after boundary", v, e);
    end
  endtask

  initial begin
    t_reset();
    t_count_pwm();
    t_presc();
    t_clrsrc();
    t_extremes();
    t_hiz();
    t_ctrl_lock();
    t_shadow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule